// File: doc/BRIEF.md
# Power-On and Pin Reset Controller

This block produces the system reset for a small microcontroller core. An internal power-on path holds the core in reset while the power-good indication is low. After power-good rises, it keeps the reset asserted for a fixed number of clock cycles. A second, optional reset source comes from a shared general-purpose pin, used as an active-low input. A non-volatile configuration bit chooses what that pin does. With the bit at 0 the pin drives reset. With the bit at 1 the pin is an ordinary input whose synchronized level is handed to the core.

The block also keeps a low-power control flag. Software sets it with a write strobe. Only the power-on path clears it, so a reset from the pin leaves the flag as it was. The system reset output is the OR of the stretched power-on reset and the enabled, synchronized pin reset.

Top module: `reset_ctrl`

## Requirements
- R1: While `pwr_good` is low, `sys_rst` is 1 at once, without waiting for a clock edge, whatever the value of `cfg_pin_rst_n`.
- R2: After `pwr_good` rises (pin idle high), `sys_rst` stays 1 through the first 63 rising clock edges and falls to 0 right after the 64th (`POR_CYCLES` = 64).
- R3: With `cfg_pin_rst_n` = 0, a low level on `rst_pin_n` sets `sys_rst` to 1 right after the second rising edge that samples it low (two-flop synchronizer).
- R4: With `cfg_pin_rst_n` = 0, `sys_rst` stays 1 as long as the pin is low, and falls to 0 right after the second rising edge that samples the pin high again.
- R5: With `cfg_pin_rst_n` = 1, the pin has no effect on `sys_rst`, and `gpio_in` takes the pin level right after the second rising edge that samples it.
- R6: With `cfg_pin_rst_n` = 0, `gpio_in` reads constant 1.
- R7: Once the power-on reset has released, `lp_set` = 1 at a rising edge sets `lp_flag` to 1 right after that edge, and the flag then stays 1.
- R8: A reset driven from the pin does not clear `lp_flag`.
- R9: `pwr_good` low clears `lp_flag` to 0 at once, and `lp_set` is ignored for as long as the power-on reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| pwr_good | input | 1 | Power-good indication, low means power is not yet valid |
| rst_pin_n | input | 1 | Shared pin: active-low reset or general-purpose input |
| cfg_pin_rst_n | input | 1 | Configuration bit, 0 enables the pin as a reset |
| lp_set | input | 1 | Software write strobe that sets the low-power flag |
| sys_rst | output | 1 | System reset, active high |
| gpio_in | output | 1 | Synchronized pin level when used as an input, 1 otherwise |
| lp_flag | output | 1 | Low-power control flag |

## Verification
The power-on release is due exactly 64 rising edges after power-good rises. The bench counts the edges and samples on the falling edge after the 63rd and after the 64th. Pin effects on `sys_rst` and `gpio_in` are due after the second rising edge that samples the new pin level. Each such check samples once after one edge, where the old value must still hold, and once after two edges. The flag update is due right after the sampling edge, and a power-good drop acts at once. Those checks sample a nanosecond after the input changes. Every input is driven on the falling edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // State of the two-flop pin synchronizer.
    typedef struct packed {
        logic meta;
        logic stable;
    } sync_st_t;

    // Level the synchronizer takes while power is not good: pin released.
    localparam logic PIN_IDLE = 1'b1;

endpackage

// File: rtl/rstc_por.sv
module rstc_por #(
    parameter int POR_CYCLES = 64
) (
    input  logic clk,
    input  logic pwr_good,
    output logic por_active
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(POR_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          active;
    } por_st_t;

    por_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.active = (st_d.cnt != CNT_MAX);
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            st_q <= '{cnt: '0, active: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign por_active = st_q.active;

    // R2: while stretching, the count advances by one each edge
    assert_por_count_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        st_q.active |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R2: once released, the power-on reset stays released
    assert_por_sticky_R2: assert property (@(posedge clk) disable iff (!pwr_good)
        !st_q.active |=> !st_q.active);

endmodule

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync
    import rstc_pkg::*;
(
    input  logic clk,
    input  logic pwr_good,
    input  logic pin_raw,
    output logic pin_sync
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta   = pin_raw;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            st_q <= '{meta: PIN_IDLE, stable: PIN_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.stable;

    // R3: the stable stage follows the first stage one edge later
    assert_sync_chain_R3: assert property (@(posedge clk) disable iff (!pwr_good)
        st_q.meta |=> st_q.stable);

endmodule

// File: rtl/rstc_lp.sv
module rstc_lp (
    input  logic clk,
    input  logic pwr_good,
    input  logic por_active,
    input  logic sw_set,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } lp_st_t;

    lp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_active) begin
            st_d.flag = 1'b0;
        end else if (sw_set) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            st_q <= '{flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R7/R8: once set, only a power loss can clear the flag
    assert_lp_sticky_R8: assert property (@(posedge clk) disable iff (!pwr_good)
        st_q.flag |=> st_q.flag);

    // R9: the flag is never set while the power-on reset is active
    assert_lp_clear_R9: assert property (@(posedge clk) disable iff (!pwr_good)
        por_active |-> !st_q.flag);

endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl #(
    parameter int POR_CYCLES = 64
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic rst_pin_n,
    input  logic cfg_pin_rst_n,
    input  logic lp_set,
    output logic sys_rst,
    output logic gpio_in,
    output logic lp_flag
);
    logic por_active;
    logic pin_level;
    logic pin_rst;

    rstc_por #(.POR_CYCLES(POR_CYCLES)) i_por (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .por_active (por_active)
    );

    rstc_pin_sync i_sync (
        .clk      (clk),
        .pwr_good (pwr_good),
        .pin_raw  (rst_pin_n),
        .pin_sync (pin_level)
    );

    rstc_lp i_lp (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .por_active (por_active),
        .sw_set     (lp_set),
        .flag       (lp_flag)
    );

    always_comb begin
        pin_rst = !cfg_pin_rst_n && !pin_level;
        sys_rst = por_active || pin_rst;
        gpio_in = cfg_pin_rst_n ? pin_level : 1'b1;
    end

    // R3: a pin held low two edges ago, with pin reset enabled, holds the core in reset
    assert_pin_rst_R3: assert property (@(posedge clk) disable iff (!pwr_good)
        (!cfg_pin_rst_n && !por_active && !$past(rst_pin_n, 2) && !$past(rst_pin_n))
            |-> sys_rst);

    // R5: with the pin as an input, reset follows only the power-on path
    assert_pin_ignored_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        (cfg_pin_rst_n && !por_active) |-> !sys_rst);

endmodule

// File: tb/test_reset_ctrl.sv
module test_reset_ctrl;
    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic rst_pin_n = 1'b1;
    logic cfg_pin_rst_n = 1'b0;
    logic lp_set = 1'b0;
    logic sys_rst, gpio_in, lp_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reset_ctrl i_reset_ctrl (
        .clk           (clk),
        .pwr_good      (pwr_good),
        .rst_pin_n     (rst_pin_n),
        .cfg_pin_rst_n (cfg_pin_rst_n),
        .lp_set        (lp_set),
        .sys_rst       (sys_rst),
        .gpio_in       (gpio_in),
        .lp_flag       (lp_flag)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1, R2, R9: power cycle with a given configuration
    task automatic t_power_cycle(input logic cfg);
        @(negedge clk);
        cfg_pin_rst_n = cfg;
        rst_pin_n = 1'b1;
        pwr_good = 1'b0;
        #1;
        chk("R1", "sys_rst while power low", sys_rst, 1'b1);
        chk("R9", "lp_flag while power low", lp_flag, 1'b0);
        @(negedge clk);
        lp_set = 1'b1;
        pwr_good = 1'b1;
        edges(10);
        chk("R9", "lp_set ignored during POR", lp_flag, 1'b0);
        lp_set = 1'b0;
        edges(53);
        chk("R2", "sys_rst after 63 edges", sys_rst, 1'b1);
        edges(1);
        chk("R2", "sys_rst after 64 edges", sys_rst, 1'b0);
        chk("R9", "lp_flag after POR release", lp_flag, 1'b0);
    endtask

    // R3, R4, R6: pin reset enabled
    task automatic t_pin_reset;
        cfg_pin_rst_n = 1'b0;
        chk("R6", "gpio_in with pin reset enabled", gpio_in, 1'b1);
        rst_pin_n = 1'b0;
        edges(1);
        chk("R3", "sys_rst one edge after pin low", sys_rst, 1'b0);
        edges(1);
        chk("R3", "sys_rst two edges after pin low", sys_rst, 1'b1);
        chk("R6", "gpio_in while pin low", gpio_in, 1'b1);
        edges(20);
        chk("R4", "sys_rst held while pin low", sys_rst, 1'b1);
        rst_pin_n = 1'b1;
        edges(1);
        chk("R4", "sys_rst one edge after pin high", sys_rst, 1'b1);
        edges(1);
        chk("R4", "sys_rst two edges after pin high", sys_rst, 1'b0);
    endtask

    // R5: pin as a general-purpose input
    task automatic t_gpio;
        cfg_pin_rst_n = 1'b1;
        rst_pin_n = 1'b0;
        edges(1);
        chk("R5", "gpio_in one edge after pin low", gpio_in, 1'b1);
        edges(1);
        chk("R5", "gpio_in two edges after pin low", gpio_in, 1'b0);
        chk("R5", "sys_rst unaffected by pin", sys_rst, 1'b0);
        edges(5);
        chk("R5", "sys_rst still unaffected", sys_rst, 1'b0);
        rst_pin_n = 1'b1;
        edges(2);
        chk("R5", "gpio_in back high", gpio_in, 1'b1);
        cfg_pin_rst_n = 1'b0;
    endtask

    // R7, R8: flag set by software, survives a pin reset
    task automatic t_lowpower;
        chk("R7", "lp_flag before write", lp_flag, 1'b0);
        lp_set = 1'b1;
        edges(1);
        lp_set = 1'b0;
        chk("R7", "lp_flag after write", lp_flag, 1'b1);
        edges(4);
        chk("R7", "lp_flag stays set", lp_flag, 1'b1);
        cfg_pin_rst_n = 1'b0;
        rst_pin_n = 1'b0;
        edges(5);
        chk("R8", "sys_rst during pin reset", sys_rst, 1'b1);
        chk("R8", "lp_flag during pin reset", lp_flag, 1'b1);
        rst_pin_n = 1'b1;
        edges(3);
        chk("R8", "lp_flag after pin reset", lp_flag, 1'b1);
        pwr_good = 1'b0;
        #1;
        chk("R9", "lp_flag cleared by power loss", lp_flag, 1'b0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1", "sys_rst at start", sys_rst, 1'b1);
        chk("R9", "lp_flag at start", lp_flag, 1'b0);
        t_power_cycle(1'b0);
        t_pin_reset();
        t_gpio();
        t_lowpower();
        t_power_cycle(1'b1);
        t_gpio();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule